// File: doc/BRIEF.md
# Streaming Peak Centroid Detector

This block sits behind a line filter and watches a stream of already-smoothed pixels that arrives two per clock, each beat tagged with the row index of its lower pixel. A pixel of value zero is background, and any unbroken stretch of nonzero pixels is a candidate peak. While a stretch is open, the block keeps its pixel count, its brightness sum, its index-weighted brightness sum, its brightest pixel and a flag that records whether any pixel rose above a ceiling.

A candidate is closed when a zero pixel follows it or when the row ends. At that point it is tested against four user limits: a minimum width, a maximum width, a floor on its brightest pixel, and a ceiling that no pixel may pass. The four tests are evaluated side by side and merged with one AND. The first candidate in stream order that passes all four is taken. Its sums go to a serial divider that produces the centre of mass in 16.4 fixed point, and the rest of the frame is ignored. The result is presented once the frame has ended.

The controller has five named states. IDLE waits for `frame_start`. SCAN tracks runs. DIVIDE runs the divider after a candidate is accepted. DRAIN waits for the end of the row when a candidate was accepted before the row ended. DONE presents the result for one cycle. The transitions are:
- IDLE→SCAN on frame start.
- SCAN→DIVIDE on accept.
- SCAN→DONE on a row end with no accept.
- DIVIDE→DONE when the divider finishes and the row has ended.
- DIVIDE→DRAIN when the divider finishes and the row is still open.
- DRAIN→DONE on row end.
- DONE→IDLE.

A frame start moves every state to SCAN.

Top module: `peak_centroid_top`

## Requirements
- R1: A run is a sequence of consecutive nonzero pixels in stream order. The lower lane (`pix_lo`, index `pix_idx`) comes before the upper lane (`pix_hi`, index `pix_idx`+1), and runs continue across beats. A zero pixel in either lane closes the open run, and a nonzero pixel after it starts a new run.
- R2: The reported position is floor(16·Σ(i·m_i) / Σ m_i) over the accepted run, where i is the pixel index and m_i is the pixel value. It is 20 bits wide, and its low 4 bits are fraction.
- R3: The reported width is the number of pixels in the accepted run.
- R4: A run qualifies only if its width is at least `cfg_min_width` and at most `cfg_max_width`. Both bounds are inclusive.
- R5: A run qualifies only if its brightest pixel is greater than or equal to `cfg_peak_floor`.
- R6: A run in which any pixel is greater than `cfg_pixel_ceiling` is rejected. A pixel equal to the ceiling is allowed.
- R7: The first qualifying run in stream order is reported. Later runs in the same frame, even brighter ones, do not change the result.
- R8: A run still open on the beat marked `row_end` is closed and evaluated at that beat. If one beat both closes a run at a zero and ends the row with a second open run, the earlier run is evaluated first.
- R9: When no run in the frame qualifies, the result reports `res_found`=0, `res_pos`=0 and `res_width`=0.
- R10: `res_valid` is a single-cycle pulse issued once per completed frame, after the `row_end` beat. The result outputs then hold their values until the next `frame_start`.
- R11: `frame_start` abandons any frame in progress. It clears the run state, so nothing carries over into the new frame, and in the following cycle it clears `res_found`, `res_pos`, `res_width` and `res_valid`.
- R12: After reset, `res_valid`, `res_found`, `res_pos` and `res_width` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle pulse that opens a frame; no pixel beat in the same cycle |
| pix_valid | input | 1 | A pixel beat is present |
| pix_lo | input | 8 | Pixel at index `pix_idx` |
| pix_hi | input | 8 | Pixel at index `pix_idx`+1 |
| pix_idx | input | 11 | Row index of the lower-lane pixel |
| row_end | input | 1 | Marks the last beat of the row |
| cfg_min_width | input | 12 | Smallest accepted run width |
| cfg_max_width | input | 12 | Largest accepted run width |
| cfg_peak_floor | input | 8 | Required minimum value of the brightest pixel |
| cfg_pixel_ceiling | input | 8 | Largest pixel value allowed in a run |
| res_valid | output | 1 | One-cycle result strobe |
| res_found | output | 1 | A qualifying run was found |
| res_pos | output | 20 | Centroid in 16.4 fixed point |
| res_width | output | 12 | Width of the accepted run |

## Verification
The test patterns are chosen so that each one separates a correct design from a specific fault.

- A single symmetric peak and a skewed peak check that the centroid and width match the defining formula.
- Runs that start in the upper lane and end in the lower lane, and pixel/zero/pixel splits within one beat, separate correct lane ordering and run splitting from errors that merge or misplace runs.
- Pairs of runs that lie exactly on and just beyond each width, floor and ceiling limit show whether each comparison is inclusive or exclusive.
- A frame with a weak run followed by a bright run shows that the first qualifying run wins.
- A frame whose final beat both closes one run and ends a second shows that the end-of-row close exists and that the earlier run has priority.
- A frame abandoned mid-run shows that accumulators do not leak into the next frame.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
    localparam int PIX_W      = 8;
    localparam int IDX_W      = 11;
    localparam int FRAC_W     = 4;
    localparam int POS_INT_W  = 16;
    localparam int LANES      = 2;
    localparam int POS_W      = POS_INT_W + FRAC_W;
    localparam int WID_W      = IDX_W + 1;
    localparam int SM_W       = PIX_W + WID_W;
    localparam int SIM_W      = PIX_W + IDX_W + WID_W;
    localparam int NUM_W      = SIM_W + FRAC_W;
    localparam int SLOTS      = 2;

    typedef struct packed {
        logic [SIM_W-1:0] sum_im;
        logic [SM_W-1:0]  sum_m;
        logic [WID_W-1:0] width;
        logic [PIX_W-1:0] peak;
        logic             over;
    } run_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCAN,
        ST_DIVIDE,
        ST_DRAIN,
        ST_DONE
    } state_t;

    function automatic run_t run_add(run_t r, logic [PIX_W-1:0] p,
                                     logic [IDX_W-1:0] i, logic [PIX_W-1:0] ceil_v);
        run_t n;
        n        = r;
        n.sum_m  = r.sum_m + SM_W'(p);
        n.sum_im = r.sum_im + (SIM_W'(p) * SIM_W'(i));
        n.width  = r.width + WID_W'(1);
        n.peak   = (p > r.peak) ? p : r.peak;
        n.over   = r.over | (p > ceil_v);
        return n;
    endfunction
endpackage

// File: rtl/peak_run_tracker.sv
module peak_run_tracker
    import pcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_lo,
    input  logic [PIX_W-1:0] pix_hi,
    input  logic [IDX_W-1:0] pix_idx,
    input  logic             row_end,
    input  logic [PIX_W-1:0] ceiling,
    output logic             zc_valid,
    output run_t             zc_run,
    output logic             ec_valid,
    output run_t             ec_run
);
    run_t             acc_q;
    run_t             cur;
    logic [PIX_W-1:0] lane_pix [LANES];
    logic             beat;

    assign lane_pix[0] = pix_lo;
    assign lane_pix[1] = pix_hi;
    assign beat        = en & pix_valid;

    always_comb begin
        cur      = acc_q;
        zc_valid = 1'b0;
        zc_run   = '0;
        ec_valid = 1'b0;
        ec_run   = '0;
        for (int l = 0; l < LANES; l++) begin
            if (lane_pix[l] != '0) begin
                cur = run_add(cur, lane_pix[l], pix_idx + IDX_W'(l), ceiling);
            end else if (cur.width != '0) begin
                zc_valid = beat;
                zc_run   = cur;
                cur      = '0;
            end
        end
        if (row_end && (cur.width != '0)) begin
            ec_valid = beat;
            ec_run   = cur;
            cur      = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
        end else if (beat) begin
            acc_q <= cur;
        end
    end
endmodule

// File: rtl/peak_run_qualifier.sv
module peak_run_qualifier
    import pcd_pkg::*;
(
    input  run_t             run,
    input  logic [WID_W-1:0] min_width,
    input  logic [WID_W-1:0] max_width,
    input  logic [PIX_W-1:0] peak_floor,
    output logic             pass
);
    logic [3:0] checks;

    always_comb begin
        checks[0] = (run.width >= min_width);
        checks[1] = (run.width <= max_width);
        checks[2] = (run.peak >= peak_floor);
        checks[3] = ~run.over;
        pass      = &checks;
    end
endmodule

// File: rtl/peak_div_restoring.sv
module peak_div_restoring
    import pcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [SM_W-1:0]  den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [SM_W-1:0]  den_q;
    logic [SM_W-1:0]  rem_q;
    logic [NUM_W-1:0] quo_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic [SM_W:0]    trial;
    logic             take;

    always_comb begin
        trial = {rem_q, quo_q[NUM_W-1]};
        take  = (trial >= {1'b0, den_q});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            den_q  <= '0;
            rem_q  <= '0;
            quo_q  <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                den_q  <= den;
                rem_q  <= '0;
                quo_q  <= num;
                cnt_q  <= CNT_W'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= take ? SM_W'(trial - {1'b0, den_q}) : trial[SM_W-1:0];
                quo_q <= {quo_q[NUM_W-2:0], take};
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign quo = quo_q;
endmodule

// File: rtl/peak_centroid_top.sv
module peak_centroid_top
    import pcd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_lo,
    input  logic [PIX_W-1:0] pix_hi,
    input  logic [IDX_W-1:0] pix_idx,
    input  logic             row_end,
    input  logic [WID_W-1:0] cfg_min_width,
    input  logic [WID_W-1:0] cfg_max_width,
    input  logic [PIX_W-1:0] cfg_peak_floor,
    input  logic [PIX_W-1:0] cfg_pixel_ceiling,
    output logic             res_valid,
    output logic             res_found,
    output logic [POS_W-1:0] res_pos,
    output logic [WID_W-1:0] res_width
);
    state_t           state_q, state_d;
    logic             slot_vld  [SLOTS];
    run_t             slot_run  [SLOTS];
    logic             slot_pass [SLOTS];
    logic             accept;
    run_t             sel_run;
    logic             div_go;
    logic             div_done;
    logic [NUM_W-1:0] div_quo;
    logic             beat_end;
    logic             end_seen_q;
    logic             got_q;
    logic [WID_W-1:0] got_width_q;

    peak_run_tracker u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (frame_start),
        .en        (state_q == ST_SCAN),
        .pix_valid (pix_valid),
        .pix_lo    (pix_lo),
        .pix_hi    (pix_hi),
        .pix_idx   (pix_idx),
        .row_end   (row_end),
        .ceiling   (cfg_pixel_ceiling),
        .zc_valid  (slot_vld[0]),
        .zc_run    (slot_run[0]),
        .ec_valid  (slot_vld[1]),
        .ec_run    (slot_run[1])
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_qual
        peak_run_qualifier u_qual (
            .run        (slot_run[s]),
            .min_width  (cfg_min_width),
            .max_width  (cfg_max_width),
            .peak_floor (cfg_peak_floor),
            .pass       (slot_pass[s])
        );
    end

    always_comb begin
        accept  = 1'b0;
        sel_run = slot_run[SLOTS-1];
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (slot_vld[s] && slot_pass[s]) begin
                accept  = 1'b1;
                sel_run = slot_run[s];
            end
        end
    end

    assign beat_end = pix_valid & row_end;
    assign div_go   = (state_q == ST_SCAN) & !frame_start & accept;

    peak_div_restoring u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (div_go),
        .num   ({sel_run.sum_im, {FRAC_W{1'b0}}}),
        .den   (sel_run.sum_m),
        .done  (div_done),
        .quo   (div_quo)
    );

    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            state_d = ST_SCAN;
        end else begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_SCAN: begin
                    if (accept)        state_d = ST_DIVIDE;
                    else if (beat_end) state_d = ST_DONE;
                end
                ST_DIVIDE: begin
                    if (div_done) state_d = (end_seen_q || beat_end) ? ST_DONE : ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (beat_end) state_d = ST_DONE;
                end
                ST_DONE:   state_d = ST_IDLE;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_seen_q  <= 1'b0;
            got_q       <= 1'b0;
            got_width_q <= '0;
            res_valid   <= 1'b0;
            res_found   <= 1'b0;
            res_pos     <= '0;
            res_width   <= '0;
        end else if (frame_start) begin
            end_seen_q  <= 1'b0;
            got_q       <= 1'b0;
            got_width_q <= '0;
            res_valid   <= 1'b0;
            res_found   <= 1'b0;
            res_pos     <= '0;
            res_width   <= '0;
        end else begin
            if (beat_end && state_q != ST_IDLE) end_seen_q <= 1'b1;
            if (div_go) begin
                got_q       <= 1'b1;
                got_width_q <= sel_run.width;
            end
            res_valid <= (state_d == ST_DONE);
            if (state_d == ST_DONE) begin
                res_found <= got_q;
                res_pos   <= got_q ? div_quo[POS_W-1:0] : '0;
                res_width <= got_q ? got_width_q : '0;
            end
        end
    end
endmodule

// File: rtl/peak_centroid_chk.sv
module peak_centroid_chk
    import pcd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             pix_valid,
    input logic [PIX_W-1:0] pix_lo,
    input logic [PIX_W-1:0] pix_hi,
    input logic [IDX_W-1:0] pix_idx,
    input logic             row_end,
    input logic [WID_W-1:0] cfg_min_width,
    input logic [WID_W-1:0] cfg_max_width,
    input logic [PIX_W-1:0] cfg_peak_floor,
    input logic [PIX_W-1:0] cfg_pixel_ceiling,
    input logic             res_valid,
    input logic             res_found,
    input logic [POS_W-1:0] res_pos,
    input logic [WID_W-1:0] res_width
);
    AST_VALID_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R10

    AST_WIDTH_IN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_found) |-> (res_width >= cfg_min_width && res_width <= cfg_max_width)); // R4

    AST_MISS_REPORTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_found) |-> (res_pos == '0 && res_width == '0)); // R9

    AST_FRAME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (!res_found && !res_valid && res_width == '0)); // R11

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> (res_valid || $stable(res_pos))); // R10

    AST_POS_WITHIN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_found) |-> (res_pos < (POS_W'(1) << (IDX_W + FRAC_W)))); // R2
endmodule

bind peak_centroid_top peak_centroid_chk chk_i (.*);

// File: tb/peak_centroid_tb.sv
module peak_centroid_top_tb_top;
    import pcd_pkg::*;

    localparam int MAXLEN = 64;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_start = 1'b0;
    logic             pix_valid = 1'b0;
    logic [PIX_W-1:0] pix_lo = '0;
    logic [PIX_W-1:0] pix_hi = '0;
    logic [IDX_W-1:0] pix_idx = '0;
    logic             row_end = 1'b0;
    logic [WID_W-1:0] cfg_min_width = '0;
    logic [WID_W-1:0] cfg_max_width = '0;
    logic [PIX_W-1:0] cfg_peak_floor = '0;
    logic [PIX_W-1:0] cfg_pixel_ceiling = '0;
    logic             res_valid;
    logic             res_found;
    logic [POS_W-1:0] res_pos;
    logic [WID_W-1:0] res_width;

    int n_chk = 0;
    int n_bad = 0;
    int row [MAXLEN];
    int row_len = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    peak_centroid_top dut_i (.*);

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int mnw, input int mxw, input int flr, input int ceil_v);
        cfg_min_width     = WID_W'(mnw);
        cfg_max_width     = WID_W'(mxw);
        cfg_peak_floor    = PIX_W'(flr);
        cfg_pixel_ceiling = PIX_W'(ceil_v);
    endtask

    task automatic clear_row(input int n);
        for (int i = 0; i < MAXLEN; i++) row[i] = 0;
        row_len = n;
    endtask

    task automatic ref_eval(output bit f, output int pos, output int w);
        longint sm, sim;
        int wd, pk, p;
        bit ov;
        f = 0; pos = 0; w = 0;
        sm = 0; sim = 0; wd = 0; pk = 0; ov = 0;
        for (int i = 0; i <= row_len; i++) begin
            p = (i < row_len) ? row[i] : 0;
            if (p != 0) begin
                sm += p; sim += longint'(p) * i; wd++;
                if (p > pk) pk = p;
                if (p > int'(cfg_pixel_ceiling)) ov = 1;
            end else if (wd > 0) begin
                if (!f && wd >= int'(cfg_min_width) && wd <= int'(cfg_max_width)
                    && pk >= int'(cfg_peak_floor) && !ov) begin
                    f = 1; pos = int'((sim * 16) / sm); w = wd;
                end
                sm = 0; sim = 0; wd = 0; pk = 0; ov = 0;
            end
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic send_beats(input int nbeats, input bit give_end);
        for (int k = 0; k < nbeats; k++) begin
            pix_valid = 1'b1;
            pix_lo    = PIX_W'(row[2*k]);
            pix_hi    = PIX_W'(row[2*k+1]);
            pix_idx   = IDX_W'(2*k);
            row_end   = give_end && (k == nbeats - 1);
            @(negedge clk);
        end
        pix_valid = 1'b0;
        row_end   = 1'b0;
        pix_lo    = '0;
        pix_hi    = '0;
    endtask

    task automatic await_result(input string req, output bit got);
        got = 0;
        for (int t = 0; t < 400 && !got; t++) begin
            if (res_valid) got = 1;
            else @(negedge clk);
        end
        chk(got, req, "res_valid seen", int'(got), 1);
    endtask

    task automatic frame_and_check(input string req);
        bit f, got;
        int pos, w;
        ref_eval(f, pos, w);
        pulse_start();
        send_beats(row_len / 2, 1'b1);
        await_result(req, got);
        if (got) begin
            chk(res_found == f, req, "found", int'(res_found), int'(f));
            chk(int'(res_pos) == pos, req, "position", int'(res_pos), pos);
            chk(int'(res_width) == w, req, "width", int'(res_width), w);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        chk(res_valid == 0, "R12", "valid after reset", int'(res_valid), 0);
        chk(res_found == 0, "R12", "found after reset", int'(res_found), 0);
        chk(res_pos == 0, "R12", "pos after reset", int'(res_pos), 0);
        chk(res_width == 0, "R12", "width after reset", int'(res_width), 0);
    endtask

    task automatic t_single_peak();
        set_cfg(1, 64, 1, 255);
        clear_row(32);
        row[10] = 10; row[11] = 40; row[12] = 80; row[13] = 40; row[14] = 10;
        frame_and_check("R2");
        clear_row(32);
        row[7] = 200; row[8] = 30; row[9] = 5;
        frame_and_check("R3");
    endtask

    task automatic t_lanes();
        set_cfg(2, 64, 1, 255);
        clear_row(32);
        row[3] = 9; row[4] = 7;                   // upper lane into lower lane
        frame_and_check("R1");
        clear_row(32);
        row[8] = 50; row[9] = 0; row[10] = 60; row[11] = 70; // split inside a beat
        frame_and_check("R1");
    endtask

    task automatic t_width_limits();
        set_cfg(3, 4, 1, 255);
        clear_row(32);
        row[2] = 90; row[3] = 90;                            // width 2, too narrow
        row[6] = 10; row[7] = 10; row[8] = 10; row[9] = 10; row[10] = 10; // width 5
        row[14] = 20; row[15] = 30; row[16] = 20;            // width 3 exactly min
        frame_and_check("R4");
        clear_row(32);
        row[4] = 1; row[5] = 2; row[6] = 3; row[7] = 4;      // width 4 exactly max
        frame_and_check("R4");
    endtask

    task automatic t_floor();
        set_cfg(1, 64, 50, 255);
        clear_row(32);
        row[2] = 49; row[3] = 30;
        row[9] = 50; row[10] = 12;
        frame_and_check("R5");
    endtask

    task automatic t_ceiling();
        set_cfg(1, 64, 1, 200);
        clear_row(32);
        row[4] = 100; row[5] = 201; row[6] = 100;
        row[12] = 200; row[13] = 100;
        frame_and_check("R6");
    endtask

    task automatic t_first_wins();
        set_cfg(1, 64, 20, 255);
        clear_row(40);
        row[5] = 25; row[6] = 25;
        row[20] = 250; row[21] = 250; row[22] = 250;
        frame_and_check("R7");
    endtask

    task automatic t_row_end();
        set_cfg(1, 64, 50, 255);
        clear_row(16);
        row[13] = 60; row[14] = 70; row[15] = 80;           // open at row end
        frame_and_check("R8");
        clear_row(8);
        row[5] = 5; row[7] = 90;                            // last beat closes two runs
        frame_and_check("R8");
        set_cfg(1, 64, 1, 255);
        frame_and_check("R8");                              // earlier run wins
    endtask

    task automatic t_none();
        set_cfg(2, 3, 100, 255);
        clear_row(32);
        row[1] = 200;
        row[5] = 20; row[6] = 20;
        row[20] = 200; row[21] = 200; row[22] = 200; row[23] = 200;
        frame_and_check("R9");
    endtask

    task automatic t_hold();
        logic [POS_W-1:0] p0;
        bit got, pulses;
        set_cfg(1, 64, 1, 255);
        clear_row(16);
        row[3] = 40; row[4] = 40;
        pulse_start();
        send_beats(8, 1'b1);
        await_result("R10", got);
        p0 = res_pos;
        pulses = 0;
        for (int t = 0; t < 60; t++) begin
            @(negedge clk);
            if (res_valid) pulses = 1;
        end
        chk(!pulses, "R10", "extra valid pulse", int'(pulses), 0);
        chk(res_pos == p0 && res_found, "R10", "held position", int'(res_pos), int'(p0));
    endtask

    task automatic t_restart();
        bit f, got;
        int pos, w;
        set_cfg(1, 64, 1, 255);
        clear_row(16);
        row[0] = 0; row[1] = 0; row[2] = 0; row[3] = 0; row[4] = 0; row[5] = 100;
        pulse_start();
        send_beats(3, 1'b0);                                // run open at idx 5
        pulse_start();
        chk(res_found == 0, "R11", "found cleared by frame_start", int'(res_found), 0);
        chk(res_width == 0, "R11", "width cleared by frame_start", int'(res_width), 0);
        clear_row(16);
        row[0] = 30; row[1] = 30;
        ref_eval(f, pos, w);
        send_beats(8, 1'b1);
        await_result("R11", got);
        chk(int'(res_width) == w, "R11", "width after restart", int'(res_width), w);
        chk(int'(res_pos) == pos, "R11", "pos after restart", int'(res_pos), pos);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_peak();
        t_lanes();
        t_width_limits();
        t_floor();
        t_ceiling();
        t_first_wins();
        t_row_end();
        t_none();
        t_hold();
        t_restart();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule